// File: doc/BRIEF.md
# I2C SCL Bit-Rate Generator

This block produces the serial clock for an I2C master. A power-of-two prescaler turns the system clock into an internal tick. Two 5-bit period counts set how many ticks SCL is driven low and how many ticks it is released. Each phase also includes a fixed number of ticks for the input synchroniser and noise-filter path. That number is 4 when the prescaler is bypassed (select 0) and 3 for any other select value.

The block senses the SCL line through a noise filter that needs two agreeing samples. It counts the high phase only once the filtered line is seen high. A slave that holds SCL low therefore lengthens the high phase instead of shortening it. The byte engine receives a one-clock strobe at the start of every low phase and every high phase.

An enable input and an internal-reset input gate the generator. While either one stops it, SCL is released and all counters sit at zero.

Top module: `i2c_scl_rate_gen`

## Requirements
- R1: With prescaler select s (0 to 7), one internal tick lasts 2^s system clocks, so every phase width in system clocks is its tick count multiplied by 2^s.
- R2: A write to the mode register (address 0) loads the prescaler select from data bits 6:4 only when data bit 3 is 1 in the same write. The mode register reads back as the select in bits 6:4, a 1 in bit 3, and 0 in all other bits.
- R3: The high-count register (address 1) and the low-count register (address 2) each store data bits 4:0. Each reads back with bits 7:5 forced to 1.
- R4: The low phase (scl_oe = 1) lasts (low count + 4) ticks when the select is 0, and (low count + 3) ticks otherwise.
- R5: When no other device holds SCL low, the high phase (scl_oe = 0) lasts (high count + 4) ticks when the select is 0, and (high count + 3) ticks otherwise.
- R6: A stored period count of 0 is used as 1, while the register still reads back 0xE0.
- R7: If another device holds SCL low during a high phase, scl_oe stays 0 and the high phase does not end. With select 0, SCL remains high for exactly (high count + 4) clocks after the line is released.
- R8: A high pulse of one internal tick on the sensed SCL during a stretched high phase is ignored. The phase stays stretched, and the following release again yields a full (high count + 4) clocks of high time.
- R9: While core_rst is 1 or core_en is 0, scl_oe is 0 and neither strobe fires. After the block is enabled again, the steady-state phase widths follow R4 and R5.
- R10: low_stb is 1 for the first system clock of each low phase. high_stb is 1 for the first system clock of each high phase that follows a low phase. The two strobes are never 1 together.
- R11: After rst_n, the select is 0 (mode reads 0x08), both counts are 31 (each reads 0xFF), and SCL is released.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_en | input | 1 | Generator enable |
| core_rst | input | 1 | Internal reset; holds the generator idle with SCL released |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 mode, 1 high count, 2 low count |
| wr_data | input | 8 | Register write data |
| scl_in | input | 1 | Sensed SCL line level |
| scl_oe | output | 1 | 1 drives SCL low, 0 releases it |
| low_stb | output | 1 | First clock of a low phase |
| high_stb | output | 1 | First clock of a high phase |
| mode_rdata | output | 8 | Mode register read value |
| high_rdata | output | 8 | High-count register read value |
| low_rdata | output | 8 | Low-count register read value |

## Verification
The assertions assume that scl_in changes only just after a rising clock edge and that each register write lasts a single cycle. They also assume that a slave starts stretching before the high-phase counter reaches its stall point. The stimulus meets these assumptions in three ways. It drives scl_in as a wired-AND of the block's own drive and a slave hold signal that is changed shortly after a rising edge. It issues every write as a one-cycle pulse between falling edges. It raises the hold only while the block itself is driving SCL low.

// File: rtl/sclgen_pkg.sv
package sclgen_pkg;
    typedef enum logic {
        PH_HIGH = 1'b0,
        PH_LOW  = 1'b1
    } phase_e;

    localparam logic [1:0] ADDR_MODE = 2'd0;
    localparam logic [1:0] ADDR_HIGH = 2'd1;
    localparam logic [1:0] ADDR_LOW  = 2'd2;
endpackage

// File: rtl/sclgen_regs.sv
module sclgen_regs
    import sclgen_pkg::*;
#(
    parameter int CNT_W    = 5,
    parameter int PSEL_W   = 3,
    parameter int REG_W    = 8,
    parameter int PSEL_LSB = 4,
    parameter int WP_BIT   = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [1:0]        wr_addr,
    input  logic [REG_W-1:0]  wr_data,
    output logic [PSEL_W-1:0] psel,
    output logic [CNT_W-1:0]  cnt_hi,
    output logic [CNT_W-1:0]  cnt_lo,
    output logic [REG_W-1:0]  mode_rdata,
    output logic [REG_W-1:0]  high_rdata,
    output logic [REG_W-1:0]  low_rdata
);
    localparam int PAD_W = REG_W - CNT_W;

    typedef struct packed {
        logic [PSEL_W-1:0] psel;
        logic [CNT_W-1:0]  hi;
        logic [CNT_W-1:0]  lo;
    } regs_t;

    regs_t regs_d, regs_q;

    always_comb begin
        regs_d = regs_q;
        if (wr_en) begin
            case (wr_addr)
                ADDR_MODE: if (wr_data[WP_BIT]) regs_d.psel = wr_data[PSEL_LSB +: PSEL_W];
                ADDR_HIGH: regs_d.hi = wr_data[CNT_W-1:0];
                ADDR_LOW:  regs_d.lo = wr_data[CNT_W-1:0];
                default:   regs_d = regs_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.psel <= '0;
            regs_q.hi   <= '1;
            regs_q.lo   <= '1;
        end else begin
            regs_q <= regs_d;
        end
    end

    always_comb begin
        mode_rdata = '0;
        mode_rdata[PSEL_LSB +: PSEL_W] = regs_q.psel;
        mode_rdata[WP_BIT] = 1'b1;
    end

    assign high_rdata = {{PAD_W{1'b1}}, regs_q.hi};
    assign low_rdata  = {{PAD_W{1'b1}}, regs_q.lo};
    assign psel   = regs_q.psel;
    assign cnt_hi = regs_q.hi;
    assign cnt_lo = regs_q.lo;

    // R2: a mode write without the protect-release bit leaves the select alone
    p_protect_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == ADDR_MODE && !wr_data[WP_BIT]) |=> $stable(psel));
endmodule

// File: rtl/sclgen_prescale.sv
module sclgen_prescale #(
    parameter int PSEL_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [PSEL_W-1:0] psel,
    output logic              tick
);
    localparam int DIV_W = (1 << PSEL_W) - 1;

    logic [DIV_W-1:0] pre_d, pre_q;
    logic [DIV_W-1:0] limit;

    always_comb begin
        limit = ~({DIV_W{1'b1}} << psel);
        tick  = run && (pre_q >= limit);
        if (!run || tick) pre_d = '0;
        else              pre_d = pre_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    // R1: with a nonzero select, ticks are never on back-to-back clocks
    p_tick_gap_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && psel != '0) |=> (!tick || !$stable(psel)));
endmodule

// File: rtl/sclgen_filter.sv
module sclgen_filter (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic tick,
    input  logic scl_in,
    output logic scl_filt
);
    typedef struct packed {
        logic smp;
        logic filt;
    } filt_t;

    filt_t f_d, f_q;

    always_comb begin
        f_d = f_q;
        if (!run) begin
            f_d = '0;
        end else if (tick) begin
            f_d.smp = scl_in;
            if (scl_in == f_q.smp) f_d.filt = scl_in;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    assign scl_filt = f_q.filt;

    // R8: a level that disagrees with the previous sample never reaches the output
    p_glitch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && scl_in != f_q.smp) |=> $stable(scl_filt));
endmodule

// File: rtl/sclgen_phase.sv
module sclgen_phase
    import sclgen_pkg::*;
#(
    parameter int CNT_W     = 5,
    parameter int PSEL_W    = 3,
    parameter int EXTRA_BYP = 4,
    parameter int EXTRA_DIV = 3,
    parameter int STALL_AT  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick,
    input  logic              scl_filt,
    input  logic [PSEL_W-1:0] psel,
    input  logic [CNT_W-1:0]  cnt_hi,
    input  logic [CNT_W-1:0]  cnt_lo,
    output logic              scl_oe,
    output logic              low_stb,
    output logic              high_stb
);
    localparam int TGT_W = $clog2((1 << CNT_W) + EXTRA_BYP + 1);

    typedef struct packed {
        phase_e           phase;
        logic [TGT_W-1:0] cnt;
        logic             lstb;
        logic             hstb;
    } ph_t;

    ph_t ph_d, ph_q;
    logic [TGT_W-1:0] tgt_hi, tgt_lo;

    function automatic logic [TGT_W-1:0] phase_len(input logic [CNT_W-1:0] c,
                                                   input logic [PSEL_W-1:0] s);
        logic [TGT_W-1:0] eff;
        eff = (c == '0) ? TGT_W'(1) : TGT_W'(c);
        return eff + ((s == '0) ? TGT_W'(EXTRA_BYP) : TGT_W'(EXTRA_DIV));
    endfunction

    always_comb begin
        tgt_hi = phase_len(cnt_hi, psel);
        tgt_lo = phase_len(cnt_lo, psel);
        ph_d = ph_q;
        ph_d.lstb = 1'b0;
        ph_d.hstb = 1'b0;
        if (!run) begin
            ph_d.phase = PH_HIGH;
            ph_d.cnt   = '0;
        end else if (tick) begin
            if (ph_q.phase == PH_LOW) begin
                if (ph_q.cnt >= tgt_lo - 1'b1) begin
                    ph_d.phase = PH_HIGH;
                    ph_d.cnt   = '0;
                    ph_d.hstb  = 1'b1;
                end else begin
                    ph_d.cnt = ph_q.cnt + 1'b1;
                end
            end else if (!scl_filt && ph_q.cnt >= TGT_W'(STALL_AT)) begin
                ph_d.cnt = ph_q.cnt;
            end else if (ph_q.cnt >= tgt_hi - 1'b1) begin
                ph_d.phase = PH_LOW;
                ph_d.cnt   = '0;
                ph_d.lstb  = 1'b1;
            end else begin
                ph_d.cnt = ph_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ph_q.phase <= PH_HIGH;
            ph_q.cnt   <= '0;
            ph_q.lstb  <= 1'b0;
            ph_q.hstb  <= 1'b0;
        end else begin
            ph_q <= ph_d;
        end
    end

    assign scl_oe   = (ph_q.phase == PH_LOW);
    assign low_stb  = ph_q.lstb;
    assign high_stb = ph_q.hstb;

    // R9: stopping the generator releases SCL and silences the strobes
    p_release_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> (!scl_oe && !low_stb && !high_stb));
    // R7: a held line freezes the high-phase count with SCL released
    p_stall_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (run && tick && ph_q.phase == PH_HIGH && !scl_filt && ph_q.cnt >= TGT_W'(STALL_AT))
        |=> (!scl_oe && $stable(ph_q.cnt)));
    // R10: every start of drive comes with the low strobe
    p_low_stb_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scl_oe) |-> low_stb);
    // R10: a release while running comes with the high strobe
    p_high_stb_r10: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(scl_oe) && $past(run)) |-> high_stb);
    // R10: strobes are exclusive
    p_stb_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({low_stb, high_stb}));
endmodule

// File: rtl/i2c_scl_rate_gen.sv
module i2c_scl_rate_gen #(
    parameter int CNT_W = 5,
    parameter int PSEL_W = 3,
    parameter int REG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             core_en,
    input  logic             core_rst,
    input  logic             wr_en,
    input  logic [1:0]       wr_addr,
    input  logic [REG_W-1:0] wr_data,
    input  logic             scl_in,
    output logic             scl_oe,
    output logic             low_stb,
    output logic             high_stb,
    output logic [REG_W-1:0] mode_rdata,
    output logic [REG_W-1:0] high_rdata,
    output logic [REG_W-1:0] low_rdata
);
    logic              run;
    logic              tick;
    logic              scl_filt;
    logic [PSEL_W-1:0] psel;
    logic [CNT_W-1:0]  cnt_hi, cnt_lo;

    assign run = core_en && !core_rst;

    sclgen_regs #(.CNT_W(CNT_W), .PSEL_W(PSEL_W), .REG_W(REG_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .psel(psel), .cnt_hi(cnt_hi), .cnt_lo(cnt_lo),
        .mode_rdata(mode_rdata), .high_rdata(high_rdata), .low_rdata(low_rdata)
    );

    sclgen_prescale #(.PSEL_W(PSEL_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(run), .psel(psel), .tick(tick)
    );

    sclgen_filter u_filt (
        .clk(clk), .rst_n(rst_n), .run(run), .tick(tick),
        .scl_in(scl_in), .scl_filt(scl_filt)
    );

    sclgen_phase #(.CNT_W(CNT_W), .PSEL_W(PSEL_W)) u_phase (
        .clk(clk), .rst_n(rst_n), .run(run), .tick(tick), .scl_filt(scl_filt),
        .psel(psel), .cnt_hi(cnt_hi), .cnt_lo(cnt_lo),
        .scl_oe(scl_oe), .low_stb(low_stb), .high_stb(high_stb)
    );
endmodule

// File: tb/sim_i2c_scl_rate_gen.sv
module sim_i2c_scl_rate_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       core_en = 1'b0;
    logic       core_rst = 1'b0;
    logic       wr_en = 1'b0;
    logic [1:0] wr_addr = 2'd0;
    logic [7:0] wr_data = 8'd0;
    logic       hold = 1'b0;
    logic       scl_line;
    logic       scl_oe, low_stb, high_stb;
    logic [7:0] mode_rdata, high_rdata, low_rdata;
    int         n_checks = 0;
    int         n_fail = 0;

    always #2 clk = ~clk;

    assign scl_line = !scl_oe && !hold;

    i2c_scl_rate_gen u0 (
        .clk(clk), .rst_n(rst_n), .core_en(core_en), .core_rst(core_rst),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .scl_in(scl_line),
        .scl_oe(scl_oe), .low_stb(low_stb), .high_stb(high_stb),
        .mode_rdata(mode_rdata), .high_rdata(high_rdata), .low_rdata(low_rdata)
    );

    task automatic check_eq(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_reg(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic setup(input int s, input int hi, input int lo);
        write_reg(2'd0, 8'((s << 4) | 8'h08));
        write_reg(2'd1, 8'(hi));
        write_reg(2'd2, 8'(lo));
    endtask

    task automatic measure(output int lw, output int hw);
        do @(negedge clk); while (scl_line !== 1'b1);
        do @(negedge clk); while (scl_line !== 1'b0);
        lw = 0;
        while (scl_line === 1'b0) begin lw++; @(negedge clk); end
        hw = 0;
        while (scl_line === 1'b1) begin hw++; @(negedge clk); end
    endtask

    task automatic t_reset_state();
        @(negedge clk);
        check_eq("R11 mode", int'(mode_rdata), 8'h08);
        check_eq("R11 high", int'(high_rdata), 8'hFF);
        check_eq("R11 low", int'(low_rdata), 8'hFF);
        check_eq("R11 scl_oe", int'(scl_oe), 0);
    endtask

    task automatic t_regs();
        write_reg(2'd0, 8'h30);
        @(negedge clk);
        check_eq("R2 protected write", int'(mode_rdata), 8'h08);
        write_reg(2'd0, 8'h38);
        @(negedge clk);
        check_eq("R2 released write", int'(mode_rdata), 8'h38);
        write_reg(2'd1, 8'h05);
        write_reg(2'd2, 8'h47);
        @(negedge clk);
        check_eq("R3 high readback", int'(high_rdata), 8'hE5);
        check_eq("R3 low readback", int'(low_rdata), 8'hE7);
    endtask

    task automatic t_rate(input int s, input int hi, input int lo);
        int lw, hw, ex;
        setup(s, hi, lo);
        measure(lw, hw);
        measure(lw, hw);
        ex = (s == 0) ? 4 : 3;
        check_eq($sformatf("R4 R1 low s=%0d", s), lw, (lo + ex) << s);
        check_eq($sformatf("R5 R1 high s=%0d", s), hw, (hi + ex) << s);
    endtask

    task automatic t_min_count();
        int lw, hw;
        setup(0, 0, 0);
        @(negedge clk);
        check_eq("R6 readback", int'(high_rdata), 8'hE0);
        measure(lw, hw);
        measure(lw, hw);
        check_eq("R6 low", lw, 5);
        check_eq("R6 high", hw, 5);
    endtask

    task automatic t_strobe();
        setup(0, 2, 3);
        do @(negedge clk); while (scl_line !== 1'b1);
        do @(negedge clk); while (scl_line !== 1'b0);
        check_eq("R10 low_stb first", int'(low_stb), 1);
        @(negedge clk);
        check_eq("R10 low_stb second", int'(low_stb), 0);
        do @(negedge clk); while (scl_line !== 1'b1);
        check_eq("R10 high_stb first", int'(high_stb), 1);
        @(negedge clk);
        check_eq("R10 high_stb second", int'(high_stb), 0);
    endtask

    task automatic t_stretch(input bit glitch);
        int hw;
        setup(0, 5, 5);
        do @(negedge clk); while (low_stb !== 1'b1);
        hold = 1'b1;
        do @(negedge clk); while (scl_oe !== 1'b0);
        repeat (10) @(negedge clk);
        check_eq("R7 held high phase", int'(scl_oe), 0);
        if (glitch) begin
            @(posedge clk); #1 hold = 1'b0;
            @(posedge clk); #1 hold = 1'b1;
            repeat (6) @(negedge clk);
            check_eq("R8 glitch ignored", int'(scl_oe), 0);
        end
        @(posedge clk); #1 hold = 1'b0;
        hw = 0;
        @(negedge clk);
        while (scl_line === 1'b1) begin hw++; @(negedge clk); end
        check_eq(glitch ? "R8 width after release" : "R7 width after release", hw, 9);
    endtask

    task automatic t_core_gate(input bit use_rst);
        int seen, lw, hw;
        setup(0, 4, 6);
        @(negedge clk);
        if (use_rst) core_rst = 1'b1; else core_en = 1'b0;
        @(negedge clk);
        seen = 0;
        repeat (60) begin
            if (scl_oe || low_stb || high_stb) seen++;
            @(negedge clk);
        end
        check_eq(use_rst ? "R9 core_rst idle" : "R9 core_en idle", seen, 0);
        core_rst = 1'b0; core_en = 1'b1;
        measure(lw, hw);
        measure(lw, hw);
        check_eq("R9 low after restart", lw, 10);
        check_eq("R9 high after restart", hw, 8);
    endtask

    initial begin
        #(4 * 150000);
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset_state();
        t_regs();
        core_en = 1'b1;
        t_rate(0, 5, 7);
        t_rate(1, 2, 4);
        t_rate(3, 1, 1);
        t_rate(2, 31, 31);
        t_rate(7, 1, 2);
        t_min_count();
        t_strobe();
        t_stretch(1'b0);
        t_stretch(1'b1);
        t_core_gate(1'b1);
        t_core_gate(1'b0);
        $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end
endmodule